// File: doc/BRIEF.md
# Arbitrating Packet Shifter for a Two-Wire Bus

This block sends one packet on an open-drain serial data line: eight data bits, most significant first, then a ninth bit during which the line is released and the receiver's acknowledge level is recorded. The clock synchronizer that serves the bus supplies two strobes. One marks a falling clock edge, where the data line may change. The other marks a rising clock edge, where the line is sampled. The block never drives the line high. It only enables a pull-low driver, so every bit it sends is also read back from the wired-AND bus.

Several masters can start a packet in the same bus cycle, so the block checks every bit. The only mismatch it can see is a bit it released (a 1) that reads back as 0, which means another master is pulling low. When that happens the block stops pulling for the rest of the packet. It still follows the strobes through all nine clocks, so the surrounding bus clock logic finishes the packet normally. When the packet ends it raises a pulse that hands the byte it captured from the bus to the local target-address check. Arbitration is checked in every packet, so a contest that continues through an identical address into the data packets is still resolved.

The control is a six-state machine. IDLE goes to SETUP on an accepted start. SETUP goes to SAMPLE on a falling strobe, which drives the next bit. SAMPLE goes back to SETUP on a rising strobe, or to ACK_SETUP when that strobe sampled the last data bit. ACK_SETUP goes to ACK_SAMPLE on a falling strobe, which releases the line. ACK_SAMPLE goes to FIN on a rising strobe, which captures the acknowledge. FIN always returns to IDLE after one cycle.

Top module: `arb_pkt_tx`

## Requirements
- R1: After reset, sda_pull, busy, done, addr_check and arb_lost are all 0.
- R2: A start pulse in IDLE loads tx_byte, and busy is 1 from the next cycle. A start pulse while busy is ignored, and the packet in flight goes on with its original byte.
- R3: sda_pull changes only in the cycle after a scl_fall strobe. For data bit k (k=0 is tx_byte bit 7), sda_pull is the inverse of the bit sent, so 1 means the line is pulled low.
- R4: On each data-bit scl_rise strobe the bus level is shifted into rx_byte from the least significant end. After eight bits, rx_byte holds the bus byte MSB-first.
- R5: arb_lost is set only by a rising strobe at which the block had released the line (sent 1) and sda_in reads 0. A sent 0 that reads back as 1 never sets it.
- R6: From the cycle arb_lost is set until the end of the packet, sda_pull stays 0. This includes the acknowledge bit.
- R7: After a loss the block still steps through all nine bit clocks. done comes at the same point as in a packet that wins.
- R8: arb_lost stays set while idle and through any number of cycles. It is cleared only when the next start is accepted.
- R9: During the ninth bit sda_pull is 0, and ack_bit takes the sda_in level at the ninth rising strobe (0 = acknowledged).
- R10: done is a one-cycle pulse in the cycle after the ninth rising strobe. addr_check pulses in the same cycle only if arb_lost is set.
- R11: When two instances share the wired-AND line and start together, the one with the numerically lower byte wins. The loser's rx_byte equals the winner's byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a packet (accepted only in IDLE) |
| tx_byte | input | 8 | Byte to send, loaded at start |
| scl_fall | input | 1 | One-cycle strobe: bus clock falling edge |
| scl_rise | input | 1 | One-cycle strobe: bus clock rising edge |
| sda_in | input | 1 | Synchronised level of the data line |
| sda_pull | output | 1 | 1 enables the pull-low driver |
| busy | output | 1 | Packet in progress |
| done | output | 1 | One-cycle end-of-packet pulse |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| addr_check | output | 1 | Pulse handing rx_byte to the target address check |
| rx_byte | output | 8 | Byte observed on the bus |
| ack_bit | output | 1 | Level sampled on the ninth bit |

## Verification
Two events can land on the same rising strobe: loss of arbitration on the least significant data bit, and the step from the data phase into the acknowledge phase. The bench creates this with two masters whose bytes differ only in bit 0. It then checks three things: the loser sets arb_lost on that strobe, it keeps the line released through the acknowledge bit, and it still raises done together with addr_check, with an rx_byte equal to the winner's byte. A second case forces a read-back of 1 while the block pulls low, to show that this mismatch never counts as a loss.

// File: rtl/arb_tx_pkg.sv
package arb_tx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_SAMPLE,
        ST_ACK_SETUP,
        ST_ACK_SAMPLE,
        ST_FIN
    } tx_state_e;
endpackage

// File: rtl/tx_shifter.sv
module tx_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    output logic         cur_bit,
    output logic         last_bit
);
    localparam int CW = (W > 1) ? $clog2(W) : 1;

    logic [W-1:0]  shreg;
    logic [CW-1:0] remain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg  <= '0;
            remain <= '0;
        end else if (load) begin
            shreg  <= load_val;
            remain <= CW'(W - 1);
        end else if (shift) begin
            shreg  <= {shreg[W-2:0], 1'b0};
            remain <= remain - 1'b1;
        end
    end

    assign cur_bit  = shreg[W-1];
    assign last_bit = (remain == '0);
endmodule

// File: rtl/arb_judge.sv
module arb_judge (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic drive_en,
    input  logic drive_bit,
    input  logic release_en,
    input  logic sample_en,
    input  logic sda_in,
    output logic sda_pull,
    output logic lost
);
    logic mismatch;

    // Only a released (high) bit read back as low counts
    assign mismatch = sample_en && !sda_pull && !sda_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lost <= 1'b0;
        end else if (clear) begin
            lost <= 1'b0;
        end else if (mismatch) begin
            lost <= 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sda_pull <= 1'b0;
        end else if (clear || release_en) begin
            sda_pull <= 1'b0;
        end else if (drive_en) begin
            sda_pull <= !drive_bit && !lost;
        end
    end
endmodule

// File: rtl/rx_capture.sv
module rx_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         ack_en,
    input  logic         sda_in,
    output logic [W-1:0] rx_byte,
    output logic         ack_bit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_byte <= '0;
            ack_bit <= 1'b1;
        end else begin
            if (shift_en) rx_byte <= {rx_byte[W-2:0], sda_in};
            if (ack_en)   ack_bit <= sda_in;
        end
    end
endmodule

// File: rtl/arb_pkt_tx.sv
module arb_pkt_tx
    import arb_tx_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] tx_byte,
    input  logic         scl_fall,
    input  logic         scl_rise,
    input  logic         sda_in,
    output logic         sda_pull,
    output logic         busy,
    output logic         done,
    output logic         arb_lost,
    output logic         addr_check,
    output logic [W-1:0] rx_byte,
    output logic         ack_bit
);
    tx_state_e state, state_nx;

    logic load, drive_en, sample_en, shift_en, release_en, ack_en;
    logic cur_bit, last_bit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:       if (start)    state_nx = ST_SETUP;
            ST_SETUP:      if (scl_fall) state_nx = ST_SAMPLE;
            ST_SAMPLE:     if (scl_rise) state_nx = last_bit ? ST_ACK_SETUP : ST_SETUP;
            ST_ACK_SETUP:  if (scl_fall) state_nx = ST_ACK_SAMPLE;
            ST_ACK_SAMPLE: if (scl_rise) state_nx = ST_FIN;
            ST_FIN:                      state_nx = ST_IDLE;
            default:                     state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load       = (state == ST_IDLE) && start;
        drive_en   = (state == ST_SETUP) && scl_fall;
        sample_en  = (state == ST_SAMPLE) && scl_rise;
        shift_en   = sample_en && !last_bit;
        release_en = (state == ST_ACK_SETUP) && scl_fall;
        ack_en     = (state == ST_ACK_SAMPLE) && scl_rise;
        busy       = (state != ST_IDLE);
        done       = (state == ST_FIN);
        addr_check = (state == ST_FIN) && arb_lost;
    end

    tx_shifter #(.W(W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (tx_byte),
        .shift    (shift_en),
        .cur_bit  (cur_bit),
        .last_bit (last_bit)
    );

    arb_judge u_judge (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (load),
        .drive_en   (drive_en),
        .drive_bit  (cur_bit),
        .release_en (release_en),
        .sample_en  (sample_en),
        .sda_in     (sda_in),
        .sda_pull   (sda_pull),
        .lost       (arb_lost)
    );

    rx_capture #(.W(W)) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sample_en),
        .ack_en   (ack_en),
        .sda_in   (sda_in),
        .rx_byte  (rx_byte),
        .ack_bit  (ack_bit)
    );
endmodule

// File: rtl/arb_pkt_tx_chk.sv
module arb_pkt_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic scl_fall,
    input logic scl_rise,
    input logic sda_in,
    input logic sda_pull,
    input logic busy,
    input logic done,
    input logic arb_lost,
    input logic addr_check
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sda_pull);

    assert_pull_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> $past(scl_fall));

    assert_loss_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |-> ($past(scl_rise) && !$past(sda_in) && !$past(sda_pull)));

    assert_released_when_lost_R6: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> !sda_pull);

    assert_lost_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (arb_lost && !(start && !busy)) |=> arb_lost);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_addr_check_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        addr_check |-> (done && arb_lost));
endmodule

bind arb_pkt_tx arb_pkt_tx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .scl_fall   (scl_fall),
    .scl_rise   (scl_rise),
    .sda_in     (sda_in),
    .sda_pull   (sda_pull),
    .busy       (busy),
    .done       (done),
    .arb_lost   (arb_lost),
    .addr_check (addr_check)
);

// File: tb/test_arb_pkt_tx.sv
`timescale 1ns/1ps
module test_arb_pkt_tx;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic start_a = 0, start_b = 0, scl_fall = 0, scl_rise = 0;
    logic inj_now = 0, force_hi = 0;
    logic [7:0] tx_a = 0, tx_b = 0;
    logic pull_a, pull_b, busy_a, busy_b, done_a, done_b;
    logic lost_a, lost_b, addr_a, addr_b, ack_a, ack_b;
    logic [7:0] rx_a, rx_b;
    logic bus, sda_a;

    assign bus   = !(pull_a || pull_b || inj_now);
    assign sda_a = force_hi ? 1'b1 : bus;

    arb_pkt_tx i_arb_pkt_tx (
        .clk(clk), .rst_n(rst_n), .start(start_a), .tx_byte(tx_a),
        .scl_fall(scl_fall), .scl_rise(scl_rise), .sda_in(sda_a),
        .sda_pull(pull_a), .busy(busy_a), .done(done_a), .arb_lost(lost_a),
        .addr_check(addr_a), .rx_byte(rx_a), .ack_bit(ack_a));

    arb_pkt_tx i_arb_pkt_tx_b (
        .clk(clk), .rst_n(rst_n), .start(start_b), .tx_byte(tx_b),
        .scl_fall(scl_fall), .scl_rise(scl_rise), .sda_in(bus),
        .sda_pull(pull_b), .busy(busy_b), .done(done_b), .arb_lost(lost_b),
        .addr_check(addr_b), .rx_byte(rx_b), .ack_bit(ack_b));

    int total = 0;
    int fails = 0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // {a, b, use_b, inject[8:0] (index 0 = first bit, 8 = ack), force_high_a, mid_start}
    localparam int NV = 9;
    localparam logic [27:0] VEC [NV] = '{
        {8'h55, 8'h00, 1'b0, 9'h000, 1'b0, 1'b0},
        {8'hA3, 8'h00, 1'b0, 9'h100, 1'b0, 1'b0},
        {8'h3C, 8'h3E, 1'b1, 9'h100, 1'b0, 1'b0},
        {8'h81, 8'h80, 1'b1, 9'h000, 1'b0, 1'b0},
        {8'hFF, 8'h00, 1'b1, 9'h100, 1'b0, 1'b0},
        {8'h5A, 8'h5A, 1'b1, 9'h100, 1'b0, 1'b0},
        {8'h00, 8'h00, 1'b0, 9'h000, 1'b1, 1'b0},
        {8'h96, 8'h00, 1'b0, 9'h000, 1'b0, 1'b1},
        {8'hF0, 8'h00, 1'b0, 9'h004, 1'b0, 1'b0}
    };

    task automatic run_vec(input logic [27:0] v);
        logic [7:0] a, b, rxa, rxb, win;
        logic ub, fhi, mid, la, lb, da, db, bt, bta, acka;
        logic [8:0] inj, epa, epb, gpa, gpb;
        {a, b, ub, inj, fhi, mid} = v;
        la = 0; lb = 0; rxa = 0; rxb = 0;
        for (int k = 0; k < 8; k++) begin
            da  = la ? 1'b1 : a[7-k];
            db  = (!ub || lb) ? 1'b1 : b[7-k];
            bt  = da && db && !inj[k];
            bta = fhi ? 1'b1 : bt;
            epa[k] = !da;
            epb[k] = ub ? !db : 1'b0;
            if (da && !bta) la = 1;
            if (ub && db && !bt) lb = 1;
            rxa = {rxa[6:0], bta};
            rxb = {rxb[6:0], bt};
        end
        epa[8] = 0; epb[8] = 0;
        acka = fhi ? 1'b1 : !inj[8];

        @(negedge clk);
        tx_a = a; tx_b = b; start_a = 1; start_b = ub; force_hi = fhi;
        @(negedge clk);
        start_a = 0; start_b = 0;
        chk(busy_a == 1'b1, "R2 busy after start", busy_a, 1);
        chk(lost_a == 1'b0, "R8 cleared by start", lost_a, 0);
        chk(pull_a == 1'b0, "R3 no pull before first fall", pull_a, 0);

        for (int k = 0; k < 9; k++) begin
            @(negedge clk); scl_fall = 1; inj_now = inj[k];
            @(negedge clk); scl_fall = 0;
            if (mid && k == 3) begin start_a = 1; tx_a = ~a; end
            @(negedge clk); start_a = 0; tx_a = a;
            scl_rise = 1; gpa[k] = pull_a; gpb[k] = pull_b;
            @(negedge clk); scl_rise = 0;
            if (k == 8) begin
                chk(done_a == 1'b1, "R7/R10 done A", done_a, 1);
                chk(lost_a == la, "R5 lost A", lost_a, la);
                chk(addr_a == la, "R10 addr_check A", addr_a, la);
                chk(rx_a == rxa, "R4 rx A", rx_a, rxa);
                chk(ack_a == acka, "R9 ack A", ack_a, acka);
                chk(gpa == epa, la ? "R6 pull log A" : "R3 pull log A", gpa, epa);
                if (mid) chk(gpa == epa, "R2 mid start ignored", gpa, epa);
                if (ub) begin
                    chk(done_b == 1'b1, "R7 done B", done_b, 1);
                    chk(lost_b == lb, "R5 lost B", lost_b, lb);
                    chk(rx_b == rxb, "R4 rx B", rx_b, rxb);
                    chk(gpb == epb, lb ? "R6 pull log B" : "R3 pull log B", gpb, epb);
                    if (a != b) begin
                        win = (a < b) ? a : b;
                        chk((a < b) ? (!lost_a && lost_b) : (lost_a && !lost_b),
                            "R11 lower byte wins", {lost_a, lost_b}, (a < b) ? 2'b01 : 2'b10);
                        chk(((a < b) ? rx_b : rx_a) == win, "R11 loser sees winner",
                            (a < b) ? rx_b : rx_a, win);
                    end
                end
            end
            @(negedge clk);
        end
        chk(done_a == 1'b0, "R10 done one cycle", done_a, 0);
        chk(busy_a == 1'b0, "R2 idle after packet", busy_a, 0);
        inj_now = 0; force_hi = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk({pull_a, busy_a, done_a, addr_a, lost_a} == 5'b0, "R1 reset state",
            {pull_a, busy_a, done_a, addr_a, lost_a}, 0);
        rst_n = 1;
        @(negedge clk);
        chk({pull_a, busy_a, done_a, addr_a, lost_a} == 5'b0, "R1 after release",
            {pull_a, busy_a, done_a, addr_a, lost_a}, 0);

        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // last vector lost: flag must hold while idle
        repeat (6) @(negedge clk);
        chk(lost_a == 1'b1, "R8 sticky while idle", lost_a, 1);
        chk(pull_a == 1'b0, "R1 idle released", pull_a, 0);
        // next start clears (checked inside run_vec)
        run_vec({8'h42, 8'h00, 1'b0, 9'h100, 1'b0, 1'b0});

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule